// File: doc/BRIEF.md
# Sliced Reuse-Cache Multiply Lane

This block is one lane of a vector-by-matrix engine that skips repeated multiplications. A scalar operand is latched at the start of a row chunk. Quantized weights from that row then arrive on P parallel weight slices. Each weight value points into a result cache that holds value × operand. The first request for a value sends it to the lane's only multiplier. Later requests for the same value read the stored product instead. The cache is split into P slices so that up to P lookups can complete in one cycle. Each lookup result is written back on the output slice that has the same number as the weight slice it came from.

Each cache slice has one request queue per weight slice in front of it. It serves these queues in round-robin order. Misses wait in one small queue per cache slice, and the shared multiplier drains those queues in round-robin order. Each output slice merges P hit queues and one multiplier-result queue. Every queue is guarded by a credit counter held on the producer side. A `start` pulse, given while the lane is idle, latches a new operand and empties the cache.

Top module: `rc_sliced_lane`

## Requirements
- R1: A weight accepted on slice s with position tag p is returned on output slice s, carrying tag p and the data value × operand, truncated to RW bits.
- R2: The cache slice for a weight is chosen by the low log2(P) bits of its value, and the entry inside that slice by the remaining high bits. Weights whose values share those low bits are served by one slice, one per cycle.
- R3: A value's first request sends one multiplication to the multiplier and marks the entry pending. A request for a pending entry waits in its queue until the product is written. A write only ever targets a pending entry.
- R4: When a cache slice has requests waiting from several weight slices, it grants them in a fixed cyclic order, so no weight slice is served twice before each of the others is served once.
- R5: No queue is ever pushed while full. `w_ready[s]` is low while the credit count for the queue that slice s is aiming at is zero.
- R6: A cache slice never reads and writes the same entry in one cycle.
- R7: When all P weights of a cycle hit in P different cache slices, the lane keeps P results per cycle going for a sustained burst.
- R8: When every weight targets the same cache slice, at most one result leaves the lane per cycle.
- R9: `start` latches `x_in` as the new operand and clears all cache entries, so no product from the previous chunk is reused.
- R10: After reset no output is valid and every `w_ready` is high.
- R11: Every accepted weight yields exactly one result, and no queue is popped while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch operand and clear cache (lane idle) |
| x_in | input | XW | Operand for the new row chunk |
| w_valid | input | P | Weight present on each slice |
| w_value | input | P*VW | Weight value per slice, slice s at bits s*VW |
| w_pos | input | P*PW | Position tag per slice |
| w_ready | output | P | Weight on that slice is taken this cycle |
| out_valid | output | P | Result present on each output slice |
| out_data | output | P*RW | Product per output slice |
| out_pos | output | P*PW | Position tag of that product |

## Verification
The bench uses the default build: four slices, an 8-bit weight value split into 2 slice bits and 6 entry bits, request queues four deep, all other queues two deep, and a three-stage multiplier. With only four slices, a single beat can send every weight to one cache slice, which exercises the pending-entry wait and the strict grant rotation. A burst of 256 distinct values overflows the two-entry miss queues within a few beats, so credit stalls at the lane's input occur. The same settings also allow a full-rate all-hit burst, so both the P-per-cycle and the one-per-cycle throughput limits can be observed at the ports.

// File: rtl/rc_lane_pkg.sv
// Shared helpers for the sliced reuse lane.
// Assumes: callers pass positive sizes.
package rc_lane_pkg;
    // Index width for n choices, never below one bit.
    function automatic int ptr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rc_fifo.sv
// Small synchronous FIFO used for every queue in the lane.
// Assumes: the producer holds a credit before pushing; the consumer pops only when nempty.
module rc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         nempty
);
    localparam int AW = rc_lane_pkg::ptr_w(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign dout   = mem[rp];
    assign nempty = (cnt != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> (cnt != CW'(DEPTH))) else $error("queue pushed while full"); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> (cnt != '0)) else $error("queue popped while empty"); // R11
endmodule

// File: rtl/rc_rr_arb.sv
// Round-robin picker over N requesters; search starts after the last grant.
// Assumes: take is raised only in a cycle where a grant is used.
module rc_rr_arb #(
    parameter int N  = 4,
    parameter int IW = rc_lane_pkg::ptr_w(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [IW-1:0] gnt,
    output logic          any
);
    logic [IW-1:0] ptr;

    // Find the first requester after the previous winner.
    always_comb begin
        any = 1'b0;
        gnt = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!any && req[j]) begin
                any = 1'b1;
                gnt = IW'(j);
            end
        end
    end

    // Remember the winner so the rotation continues after it.
    always_ff @(posedge clk) begin
        if (!rst_n)           ptr <= IW'(N - 1);
        else if (take && any) ptr <= gnt;
    end
endmodule

// File: rtl/rc_cache_slice.sv
// One result-cache slice: arbitrates its P request queues, answers hits from
// storage, forwards misses to the multiplier and accepts multiplier write-back.
// Assumes: clear is raised only while no request or multiply is outstanding.
module rc_cache_slice #(
    parameter int P  = 4,
    parameter int SW = 2,
    parameter int EW = 6,
    parameter int RW = 16,
    parameter int PW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [P-1:0]         q_nempty,
    input  logic [P-1:0][EW-1:0] q_ent,
    input  logic [P-1:0][PW-1:0] q_pos,
    output logic [P-1:0]         q_pop,
    input  logic [P-1:0]         hit_ok,
    input  logic                 miss_ok,
    output logic                 hit_push,
    output logic [SW-1:0]        hit_dst,
    output logic [RW-1:0]        hit_data,
    output logic [PW-1:0]        hit_pos,
    output logic                 miss_push,
    output logic [SW-1:0]        miss_dst,
    output logic [EW-1:0]        miss_ent,
    output logic [PW-1:0]        miss_pos,
    input  logic                 wr_en,
    input  logic [EW-1:0]        wr_ent,
    input  logic [RW-1:0]        wr_data
);
    localparam int ENT = 1 << EW;

    logic [RW-1:0]  mem [ENT];
    logic [ENT-1:0] vld, pnd;
    logic [P-1:0]   elig;
    logic [SW-1:0]  gnt;
    logic           any;
    logic [EW-1:0]  rd_ent;
    logic           is_hit;

    // A queue head may go if its entry is settled and its destination has credit.
    always_comb begin
        for (int s = 0; s < P; s++) begin
            elig[s] = q_nempty[s] && !pnd[q_ent[s]] &&
                      (vld[q_ent[s]] ? hit_ok[s] : miss_ok);
        end
    end

    rc_rr_arb #(.N(P), .IW(SW)) i_arb (
        .clk(clk), .rst_n(rst_n), .req(elig), .take(any), .gnt(gnt), .any(any)
    );

    // Route the granted head to the hit path or the miss path.
    always_comb begin
        rd_ent    = q_ent[gnt];
        is_hit    = vld[rd_ent];
        q_pop     = any ? (P'(1) << gnt) : '0;
        hit_push  = any && is_hit;
        hit_dst   = gnt;
        hit_data  = mem[rd_ent];
        hit_pos   = q_pos[gnt];
        miss_push = any && !is_hit;
        miss_dst  = gnt;
        miss_ent  = rd_ent;
        miss_pos  = q_pos[gnt];
    end

    // Entry state: pending on miss issue, valid on write-back, cleared per chunk.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld <= '0;
            pnd <= '0;
        end else begin
            if (miss_push) pnd[rd_ent] <= 1'b1;
            if (wr_en) begin
                vld[wr_ent] <= 1'b1;
                pnd[wr_ent] <= 1'b0;
            end
        end
    end

    // Product storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ent] <= wr_data;
    end

    AST_RW_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && any) |-> (wr_ent != rd_ent)) else $error("read and write on one entry"); // R6
    AST_WR_PENDING: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> pnd[wr_ent]) else $error("write to entry not pending"); // R3
endmodule

// File: rtl/rc_mult.sv
// Shared multiplier: round-robin over the P miss queues, LAT-stage pipeline,
// result broadcast to the owning cache slice and the destination output slice.
// Assumes: mres_ok[s] reflects a reserved slot in output slice s's result queue.
module rc_mult #(
    parameter int P   = 4,
    parameter int SW  = 2,
    parameter int EW  = 6,
    parameter int XW  = 8,
    parameter int RW  = 16,
    parameter int PW  = 8,
    parameter int LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XW-1:0]        x,
    input  logic [P-1:0]         mq_nempty,
    input  logic [P-1:0][SW-1:0] mq_dst,
    input  logic [P-1:0][EW-1:0] mq_ent,
    input  logic [P-1:0][PW-1:0] mq_pos,
    input  logic [P-1:0]         mres_ok,
    output logic [P-1:0]         mq_pop,
    output logic                 issue,
    output logic [SW-1:0]        issue_dst,
    output logic                 res_valid,
    output logic [SW-1:0]        res_slice,
    output logic [EW-1:0]        res_ent,
    output logic [SW-1:0]        res_dst,
    output logic [PW-1:0]        res_pos,
    output logic [RW-1:0]        res_data
);
    localparam int VW = EW + SW;

    logic [P-1:0]   elig;
    logic [SW-1:0]  gnt;
    logic [VW-1:0]  opv;
    logic [RW-1:0]  prod;
    logic [LAT-1:0] pv;
    logic [SW-1:0]  pc [LAT];
    logic [EW-1:0]  pe [LAT];
    logic [SW-1:0]  pd [LAT];
    logic [PW-1:0]  pp [LAT];
    logic [RW-1:0]  px [LAT];

    // A miss may issue only if its output slice has a free result slot.
    always_comb begin
        for (int c = 0; c < P; c++) elig[c] = mq_nempty[c] && mres_ok[mq_dst[c]];
    end

    rc_rr_arb #(.N(P), .IW(SW)) i_arb (
        .clk(clk), .rst_n(rst_n), .req(elig), .take(issue), .gnt(gnt), .any(issue)
    );

    // Rebuild the full weight value from entry bits and slice number.
    always_comb begin
        opv       = {mq_ent[gnt], gnt};
        prod      = RW'(opv) * RW'(x);
        issue_dst = mq_dst[gnt];
        mq_pop    = issue ? (P'(1) << gnt) : '0;
    end

    // Valid bits of the multiply pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
        end else begin
            pv[0] <= issue;
            for (int k = 1; k < LAT; k++) pv[k] <= pv[k-1];
        end
    end

    // Tags and product carried alongside the valid bits.
    always_ff @(posedge clk) begin
        pc[0] <= gnt;
        pe[0] <= mq_ent[gnt];
        pd[0] <= mq_dst[gnt];
        pp[0] <= mq_pos[gnt];
        px[0] <= prod;
        for (int k = 1; k < LAT; k++) begin
            pc[k] <= pc[k-1];
            pe[k] <= pe[k-1];
            pd[k] <= pd[k-1];
            pp[k] <= pp[k-1];
            px[k] <= px[k-1];
        end
    end

    assign res_valid = pv[LAT-1];
    assign res_slice = pc[LAT-1];
    assign res_ent   = pe[LAT-1];
    assign res_dst   = pd[LAT-1];
    assign res_pos   = pp[LAT-1];
    assign res_data  = px[LAT-1];
endmodule

// File: rtl/rc_sliced_lane.sv
// Sliced reuse lane: P weight slices feed P cache slices through per-pair
// request queues; misses share one multiplier; each output slice merges P hit
// queues and one multiplier queue. All queues are guarded by producer credits.
// Assumes: P is a power of two, RW >= VW + XW, start only while idle.
module rc_sliced_lane #(
    parameter int P        = 4,
    parameter int VW       = 8,
    parameter int XW       = 8,
    parameter int RW       = 16,
    parameter int PW       = 8,
    parameter int RQ_DEPTH = 4,
    parameter int HQ_DEPTH = 2,
    parameter int MQ_DEPTH = 2,
    parameter int MR_DEPTH = 2,
    parameter int LAT      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XW-1:0]   x_in,
    input  logic [P-1:0]    w_valid,
    input  logic [P*VW-1:0] w_value,
    input  logic [P*PW-1:0] w_pos,
    output logic [P-1:0]    w_ready,
    output logic [P-1:0]    out_valid,
    output logic [P*RW-1:0] out_data,
    output logic [P*PW-1:0] out_pos
);
    localparam int SW  = $clog2(P);
    localparam int EW  = VW - SW;
    localparam int RQW = EW + PW;
    localparam int MQW = SW + PW + EW;
    localparam int OQW = PW + RW;
    localparam int OIW = rc_lane_pkg::ptr_w(P + 1);
    localparam int RCW = $clog2(RQ_DEPTH + 1);
    localparam int HCW = $clog2(HQ_DEPTH + 1);
    localparam int MCW = $clog2(MQ_DEPTH + 1);
    localparam int OCW = $clog2(MR_DEPTH + 1);

    logic [XW-1:0]        x_q;
    logic [SW-1:0]        w_tgt [P];
    logic [EW-1:0]        w_ent [P];
    logic [PW-1:0]        w_p   [P];

    logic [P-1:0]         rq_push [P];
    logic [P-1:0]         rq_pop  [P];
    logic [P-1:0]         rq_ne   [P];
    logic [RQW-1:0]       rq_dout [P][P];
    logic [P-1:0][EW-1:0] rq_ent  [P];
    logic [P-1:0][PW-1:0] rq_pos  [P];
    logic [RCW-1:0]       req_cred [P][P];

    logic [P-1:0]         hok [P];
    logic [HCW-1:0]       hit_cred [P][P];
    logic                 hit_push [P];
    logic [SW-1:0]        hit_dst  [P];
    logic [RW-1:0]        hit_data [P];
    logic [PW-1:0]        hit_pos  [P];

    logic                 miss_push [P];
    logic [SW-1:0]        miss_dst  [P];
    logic [EW-1:0]        miss_ent  [P];
    logic [PW-1:0]        miss_pos  [P];
    logic [MCW-1:0]       miss_cred [P];
    logic [MQW-1:0]       mq_dout   [P];
    logic [P-1:0]         mq_ne;
    logic [P-1:0]         mq_pop;
    logic [P-1:0][SW-1:0] mq_dst;
    logic [P-1:0][EW-1:0] mq_ent;
    logic [P-1:0][PW-1:0] mq_pos;

    logic [P-1:0]         mres_ok;
    logic [OCW-1:0]       mres_cred [P];
    logic                 issue;
    logic [SW-1:0]        issue_dst;
    logic                 res_valid;
    logic [SW-1:0]        res_slice, res_dst;
    logic [EW-1:0]        res_ent;
    logic [PW-1:0]        res_pos;
    logic [RW-1:0]        res_data;

    logic [P:0]           oq_ne   [P];
    logic [P:0]           oq_pop  [P];
    logic [OQW-1:0]       oq_dout [P][P+1];

    // Operand register, loaded at the start of each row chunk.
    always_ff @(posedge clk) begin
        if (!rst_n)     x_q <= '0;
        else if (start) x_q <= x_in;
    end

    // Split each weight into owning slice (low bits), entry and tag; gate on credit.
    always_comb begin
        for (int s = 0; s < P; s++) begin
            w_tgt[s]   = w_value[s*VW +: SW];
            w_ent[s]   = w_value[s*VW+SW +: EW];
            w_p[s]     = w_pos[s*PW +: PW];
            w_ready[s] = (req_cred[w_tgt[s]][s] != '0);
        end
        for (int c = 0; c < P; c++) begin
            for (int s = 0; s < P; s++) begin
                rq_push[c][s] = w_valid[s] && w_ready[s] && (w_tgt[s] == SW'(c));
                hok[c][s]     = (hit_cred[s][c] != '0);
            end
            mres_ok[c] = (mres_cred[c] != '0);
        end
    end

    // Producer-side credit counters for every queue class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < P; c++) begin
                for (int s = 0; s < P; s++) begin
                    req_cred[c][s] <= RCW'(RQ_DEPTH);
                    hit_cred[c][s] <= HCW'(HQ_DEPTH);
                end
                miss_cred[c] <= MCW'(MQ_DEPTH);
                mres_cred[c] <= OCW'(MR_DEPTH);
            end
        end else begin
            for (int c = 0; c < P; c++) begin
                for (int s = 0; s < P; s++) begin
                    req_cred[c][s] <= req_cred[c][s] - RCW'(rq_push[c][s]) + RCW'(rq_pop[c][s]);
                    hit_cred[s][c] <= hit_cred[s][c]
                                    - HCW'(hit_push[c] && (hit_dst[c] == SW'(s)))
                                    + HCW'(oq_pop[s][c]);
                end
                miss_cred[c] <= miss_cred[c] - MCW'(miss_push[c]) + MCW'(mq_pop[c]);
                mres_cred[c] <= mres_cred[c] - OCW'(issue && (issue_dst == SW'(c)))
                                + OCW'(oq_pop[c][P]);
            end
        end
    end

    // Cache-side structure: request queues, one cache slice, one miss queue each.
    for (genvar c = 0; c < P; c++) begin : g_cache
        for (genvar s = 0; s < P; s++) begin : g_rq
            rc_fifo #(.W(RQW), .DEPTH(RQ_DEPTH)) i_rq (
                .clk(clk), .rst_n(rst_n), .push(rq_push[c][s]),
                .din({w_ent[s], w_p[s]}), .pop(rq_pop[c][s]),
                .dout(rq_dout[c][s]), .nempty(rq_ne[c][s])
            );
            assign rq_ent[c][s] = rq_dout[c][s][PW +: EW];
            assign rq_pos[c][s] = rq_dout[c][s][PW-1:0];
        end

        rc_cache_slice #(.P(P), .SW(SW), .EW(EW), .RW(RW), .PW(PW)) i_slice (
            .clk(clk), .rst_n(rst_n), .clear(start),
            .q_nempty(rq_ne[c]), .q_ent(rq_ent[c]), .q_pos(rq_pos[c]), .q_pop(rq_pop[c]),
            .hit_ok(hok[c]), .miss_ok(miss_cred[c] != '0),
            .hit_push(hit_push[c]), .hit_dst(hit_dst[c]), .hit_data(hit_data[c]), .hit_pos(hit_pos[c]),
            .miss_push(miss_push[c]), .miss_dst(miss_dst[c]), .miss_ent(miss_ent[c]), .miss_pos(miss_pos[c]),
            .wr_en(res_valid && (res_slice == SW'(c))), .wr_ent(res_ent), .wr_data(res_data)
        );

        rc_fifo #(.W(MQW), .DEPTH(MQ_DEPTH)) i_mq (
            .clk(clk), .rst_n(rst_n), .push(miss_push[c]),
            .din({miss_dst[c], miss_pos[c], miss_ent[c]}), .pop(mq_pop[c]),
            .dout(mq_dout[c]), .nempty(mq_ne[c])
        );
        assign mq_ent[c] = mq_dout[c][EW-1:0];
        assign mq_pos[c] = mq_dout[c][EW +: PW];
        assign mq_dst[c] = mq_dout[c][EW+PW +: SW];
    end

    rc_mult #(.P(P), .SW(SW), .EW(EW), .XW(XW), .RW(RW), .PW(PW), .LAT(LAT)) i_mult (
        .clk(clk), .rst_n(rst_n), .x(x_q),
        .mq_nempty(mq_ne), .mq_dst(mq_dst), .mq_ent(mq_ent), .mq_pos(mq_pos),
        .mres_ok(mres_ok), .mq_pop(mq_pop), .issue(issue), .issue_dst(issue_dst),
        .res_valid(res_valid), .res_slice(res_slice), .res_ent(res_ent),
        .res_dst(res_dst), .res_pos(res_pos), .res_data(res_data)
    );

    // Output side: P hit queues plus one multiplier queue per slice, merged round-robin.
    for (genvar s = 0; s < P; s++) begin : g_out
        logic [OIW-1:0] o_gnt;
        logic           o_any;

        for (genvar c = 0; c < P; c++) begin : g_hq
            rc_fifo #(.W(OQW), .DEPTH(HQ_DEPTH)) i_hq (
                .clk(clk), .rst_n(rst_n),
                .push(hit_push[c] && (hit_dst[c] == SW'(s))),
                .din({hit_pos[c], hit_data[c]}), .pop(oq_pop[s][c]),
                .dout(oq_dout[s][c]), .nempty(oq_ne[s][c])
            );
        end

        rc_fifo #(.W(OQW), .DEPTH(MR_DEPTH)) i_mr (
            .clk(clk), .rst_n(rst_n),
            .push(res_valid && (res_dst == SW'(s))),
            .din({res_pos, res_data}), .pop(oq_pop[s][P]),
            .dout(oq_dout[s][P]), .nempty(oq_ne[s][P])
        );

        rc_rr_arb #(.N(P + 1), .IW(OIW)) i_oarb (
            .clk(clk), .rst_n(rst_n), .req(oq_ne[s]), .take(o_any), .gnt(o_gnt), .any(o_any)
        );

        assign oq_pop[s]             = o_any ? ((P+1)'(1) << o_gnt) : '0;
        assign out_valid[s]          = o_any;
        assign out_data[s*RW +: RW]  = oq_dout[s][o_gnt][RW-1:0];
        assign out_pos[s*PW +: PW]   = oq_dout[s][o_gnt][RW +: PW];
    end
endmodule

// File: tb/test_rc_sliced_lane.sv
module test_rc_sliced_lane;
    localparam int P  = 4;
    localparam int VW = 8;
    localparam int XW = 8;
    localparam int RW = 16;
    localparam int PW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [XW-1:0]   x_in = '0;
    logic [P-1:0]    w_valid = '0;
    logic [P*VW-1:0] w_value = '0;
    logic [P*PW-1:0] w_pos = '0;
    logic [P-1:0]    w_ready;
    logic [P-1:0]    out_valid;
    logic [P*RW-1:0] out_data;
    logic [P*PW-1:0] out_pos;

    always #5 clk = ~clk;

    rc_sliced_lane i_rc_sliced_lane (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .w_valid(w_valid), .w_value(w_value), .w_pos(w_pos), .w_ready(w_ready),
        .out_valid(out_valid), .out_data(out_data), .out_pos(out_pos)
    );

    int checks = 0;
    int errors = 0;
    logic [PW+RW-1:0] exp_q [P][$];
    logic [PW-1:0]    pos_ctr [P];
    logic [XW-1:0]    x_cur = '0;
    int phase = 0;
    int all4_cnt = 0;
    int max_ones = 0;
    bit saw_stall = 1'b0;
    int d_order [$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pop and compare each result against the scoreboard of its slice.
    always @(negedge clk) begin
        int ones;
        if (rst_n) begin
            ones = $countones(out_valid);
            if (phase == 3 && ones == P) all4_cnt++;
            if (phase == 4 && ones > max_ones) max_ones = ones;
            for (int s = 0; s < P; s++) begin
                logic [PW-1:0] p;
                logic [RW-1:0] d;
                int idx;
                if (out_valid[s]) begin
                    p = out_pos[s*PW +: PW];
                    d = out_data[s*RW +: RW];
                    idx = -1;
                    for (int i = 0; i < exp_q[s].size(); i++)
                        if (idx < 0 && exp_q[s][i][RW +: PW] == p) idx = i;
                    if (idx < 0) begin
                        chk(1'b0, "R1 result with unknown tag", int'(p), -1);
                    end else begin
                        chk(exp_q[s][idx][RW-1:0] == d, "R1 product on matching slice", int'(d), int'(exp_q[s][idx][RW-1:0]));
                        exp_q[s].delete(idx);
                    end
                    if (phase == 4) d_order.push_back(s);
                end
            end
        end
    end

    // Driver: offer one beat (entered at a falling edge), push expected items as slices are taken.
    task automatic send_beat(input logic [P*VW-1:0] vals);
        logic [P-1:0] pend;
        pend = '1;
        w_value = vals;
        for (int s = 0; s < P; s++) w_pos[s*PW +: PW] = pos_ctr[s];
        while (pend != '0) begin
            w_valid = pend;
            #1;
            if ((pend & ~w_ready) != '0) saw_stall = 1'b1;
            for (int s = 0; s < P; s++) begin
                if (pend[s] && w_ready[s]) begin
                    exp_q[s].push_back({pos_ctr[s], RW'(vals[s*VW +: VW]) * RW'(x_cur)});
                    pos_ctr[s] = pos_ctr[s] + 1'b1;
                    pend[s] = 1'b0;
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic drain(input string req);
        int left;
        w_valid = '0;
        for (int n = 0; n < 3000; n++) begin
            left = 0;
            for (int s = 0; s < P; s++) left += exp_q[s].size();
            if (left == 0) break;
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
        left = 0;
        for (int s = 0; s < P; s++) left += exp_q[s].size();
        chk(left == 0, req, left, 0);
    endtask

    task automatic new_chunk(input logic [XW-1:0] x);
        @(negedge clk);
        start = 1'b1;
        x_in = x;
        x_cur = x;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [P*VW-1:0] beat(input int b0, input int b1, input int b2, input int b3);
        return {VW'(b3), VW'(b2), VW'(b1), VW'(b0)};
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0;
        for (int s = 0; s < P; s++) pos_ctr[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet outputs and open inputs after reset
        chk(out_valid == '0, "R10 out_valid after reset", int'(out_valid), 0);
        chk(w_ready == '1, "R10 w_ready after reset", int'(w_ready), 15);

        new_chunk(8'd7);

        // R3: same fresh value on all slices; one miss, three wait on the pending entry
        send_beat(beat(9, 9, 9, 9));
        drain("R3 pending-entry requests all answered");

        // R5 R6 R11: 256 distinct misses, miss queues back up into the inputs
        for (int k = 0; k < 64; k++) send_beat(beat(4*k, 4*k+1, 4*k+2, 4*k+3));
        drain("R6 R11 every miss result returned");
        chk(saw_stall, "R5 credit stall seen at inputs", int'(saw_stall), 1);

        // R7: all hits, every weight in its own cache slice
        phase = 3;
        for (int k = 0; k < 32; k++) send_beat(beat(4*k, 4*k+1, 4*k+2, 4*k+3));
        drain("R7 burst results returned");
        phase = 0;
        chk(all4_cnt >= 31, "R7 cycles with P results", all4_cnt, 31);

        // R2 R8 R4: all weights own low bits 00, so cache slice 0 serves everything
        phase = 4;
        t0 = 0;
        for (int k = 0; k < 16; k++)
            send_beat(beat((4*(4*k))   & 255, (4*(4*k+1)) & 255,
                           (4*(4*k+2)) & 255, (4*(4*k+3)) & 255));
        drain("R2 single-slice results returned");
        phase = 0;
        chk(max_ones <= 1, "R8 results per cycle on one slice", max_ones, 1);
        chk(d_order.size() == 64, "R11 one result per weight", d_order.size(), 64);
        if (d_order.size() >= 4) begin
            bit distinct4;
            bit periodic;
            distinct4 = (d_order[0] != d_order[1]) && (d_order[0] != d_order[2]) &&
                        (d_order[0] != d_order[3]) && (d_order[1] != d_order[2]) &&
                        (d_order[1] != d_order[3]) && (d_order[2] != d_order[3]);
            periodic = 1'b1;
            for (int i = 4; i < d_order.size(); i++)
                if (d_order[i] != d_order[i-4]) periodic = 1'b0;
            chk(distinct4, "R4 first rotation covers all slices", int'(distinct4), 1);
            chk(periodic, "R4 grant rotation is cyclic", int'(periodic), 1);
        end

        // R9: new operand; previously cached values must be recomputed
        new_chunk(8'd3);
        @(negedge clk);
        for (int k = 0; k < 8; k++) send_beat(beat(4*k, 4*k+1, 4*k+2, 4*k+3));
        drain("R9 products use the new operand");

        // R10 R11: idle again, nothing left over
        repeat (4) @(negedge clk);
        chk(out_valid == '0, "R11 no extra results", int'(out_valid), 0);
        chk(w_ready == '1, "R10 credits fully returned", int'(w_ready), 15);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule